// File: doc/BRIEF.md
# Single-Cycle Control Decoder

This block turns the opcode and function fields of a 32-bit instruction into every control line that a single-cycle datapath needs for a small instruction subset. That subset is register-register add, subtract, and, or and set-less-than, word load, word store, branch-if-equal and an unconditional jump. The block is purely combinational. Its outputs settle within the same cycle that the instruction word is presented.

Decoding takes place in two levels. A main decoder looks only at the opcode. It produces the datapath steering bits and a 2-bit ALU class. A second decoder combines that class with the function field to pick the 4-bit ALU operation. Opcodes outside the subset must leave the machine in a state that writes nothing. The same holds for register-register function codes outside the subset.

Top module: `ctl_decoder_top`

## Requirements
- R1: Opcode 000000 with a recognised function code gives dst_rd=1, opb_imm=0, wb_mem=0, rf_wr=1, dm_rd=0, dm_wr=0, br_eq=0, jmp=0, alu_cls=10.
- R2: Under alu_cls 10, the function code selects alu_op: 100000 gives 0010 (add), 100010 gives 0110 (subtract), 100100 gives 0000 (and), 100101 gives 0001 (or), and 101010 gives 0111 (set-less-than).
- R3: Opcode 000000 with any other function code drives every single-bit output to 0, keeps alu_cls=10 and gives alu_op=0000.
- R4: Opcode 100011 (load) gives dst_rd=0, opb_imm=1, wb_mem=1, rf_wr=1, dm_rd=1, dm_wr=0, br_eq=0, jmp=0, alu_cls=00, alu_op=0010.
- R5: Opcode 101011 (store) gives opb_imm=1, dm_wr=1, alu_cls=00 and alu_op=0010. All other single-bit outputs are 0, including the don't-care dst_rd and wb_mem.
- R6: Opcode 000100 (branch-if-equal) gives br_eq=1, alu_cls=01 and alu_op=0110. All other single-bit outputs are 0.
- R7: Opcode 000010 (jump) gives jmp=1, alu_cls=00 and alu_op=0010. All other single-bit outputs are 0.
- R8: Any other opcode drives every single-bit output to 0 and gives alu_cls=11 and alu_op=0000.
- R9: For every opcode other than 000000, the function field has no effect on any output.
- R10: At most one of rf_wr, dm_wr, br_eq and jmp is 1 at any time. dm_rd=1 only occurs together with wb_mem=1 and rf_wr=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Instruction opcode field |
| funct | input | 6 | Instruction function field (register-register forms) |
| dst_rd | output | 1 | Destination register taken from the rd field (else rt) |
| opb_imm | output | 1 | Second ALU operand is the extended immediate |
| wb_mem | output | 1 | Register write-back data comes from data memory |
| rf_wr | output | 1 | Register file write enable |
| dm_rd | output | 1 | Data memory read enable |
| dm_wr | output | 1 | Data memory write enable |
| br_eq | output | 1 | Conditional branch on equality |
| jmp | output | 1 | Next PC taken from the jump target |
| alu_cls | output | 2 | ALU class from the main decoder |
| alu_op | output | 4 | Final ALU operation |

## Verification
The bench goes after the function field on non-register opcodes. A decoder that let it leak into the second stage would give a load or branch the wrong ALU operation. Register-register opcodes with unlisted function codes, such as 000000 and 100001, are aimed at designs that still raise the register write, or that fall through to some default ALU operation. Opcodes adjacent to the valid ones are driven as well, along with the jump, to expose partial opcode matching or a stray write enable. Together these would corrupt register or memory state on an illegal instruction. Thousands of random opcode and function pairs, weighted toward the legal set, are compared against a model built from the requirements.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int OPC_W   = 6;
    localparam int FN_W    = 6;
    localparam int AOP_W   = 4;
    localparam int CLS_W   = 2;
    localparam int NUM_RFN = 5;

    typedef enum logic [OPC_W-1:0] {
        OPC_RTYPE = 6'b000000,
        OPC_JUMP  = 6'b000010,
        OPC_BREQ  = 6'b000100,
        OPC_LOAD  = 6'b100011,
        OPC_STORE = 6'b101011
    } opcode_e;

    typedef enum logic [CLS_W-1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_FUNCT = 2'b10,
        CLS_NONE  = 2'b11
    } alu_cls_e;

    typedef enum logic [AOP_W-1:0] {
        AOP_AND = 4'b0000,
        AOP_OR  = 4'b0001,
        AOP_ADD = 4'b0010,
        AOP_SUB = 4'b0110,
        AOP_SLT = 4'b0111
    } alu_op_e;

    typedef struct packed {
        logic     dst_rd;
        logic     opb_imm;
        logic     wb_mem;
        logic     rf_wr;
        logic     dm_rd;
        logic     dm_wr;
        logic     br_eq;
        logic     jmp;
        alu_cls_e cls;
    } ctl_word_t;

    localparam ctl_word_t CTL_QUIET = '{
        dst_rd: 1'b0, opb_imm: 1'b0, wb_mem: 1'b0, rf_wr: 1'b0,
        dm_rd: 1'b0, dm_wr: 1'b0, br_eq: 1'b0, jmp: 1'b0, cls: CLS_NONE
    };

    // Function-code table entry i: code and resulting ALU operation.
    function automatic logic [FN_W-1:0] rfn_code(input int idx);
        case (idx)
            0:       rfn_code = 6'b100000;
            1:       rfn_code = 6'b100010;
            2:       rfn_code = 6'b100100;
            3:       rfn_code = 6'b100101;
            default: rfn_code = 6'b101010;
        endcase
    endfunction

    function automatic alu_op_e rfn_alu(input int idx);
        case (idx)
            0:       rfn_alu = AOP_ADD;
            1:       rfn_alu = AOP_SUB;
            2:       rfn_alu = AOP_AND;
            3:       rfn_alu = AOP_OR;
            default: rfn_alu = AOP_SLT;
        endcase
    endfunction

endpackage

// File: rtl/ctl_main_dec.sv
module ctl_main_dec
    import ctl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output ctl_word_t        word_o
);
    always_comb begin
        word_o = CTL_QUIET;
        case (opcode_i)
            OPC_RTYPE: begin
                word_o.dst_rd = 1'b1;
                word_o.rf_wr  = 1'b1;
                word_o.cls    = CLS_FUNCT;
            end
            OPC_LOAD: begin
                word_o.opb_imm = 1'b1;
                word_o.wb_mem  = 1'b1;
                word_o.rf_wr   = 1'b1;
                word_o.dm_rd   = 1'b1;
                word_o.cls     = CLS_ADD;
            end
            OPC_STORE: begin
                word_o.opb_imm = 1'b1;
                word_o.dm_wr   = 1'b1;
                word_o.cls     = CLS_ADD;
            end
            OPC_BREQ: begin
                word_o.br_eq = 1'b1;
                word_o.cls   = CLS_SUB;
            end
            OPC_JUMP: begin
                word_o.jmp = 1'b1;
                word_o.cls = CLS_ADD;
            end
            default: word_o = CTL_QUIET;
        endcase
    end
endmodule

// File: rtl/ctl_alu_dec.sv
module ctl_alu_dec
    import ctl_pkg::*;
(
    input  alu_cls_e         cls_i,
    input  logic [FN_W-1:0]  funct_i,
    output alu_op_e          op_o,
    output logic             funct_ok_o
);
    logic [NUM_RFN-1:0] hit;
    logic [AOP_W-1:0]   fn_op;

    for (genvar g = 0; g < NUM_RFN; g++) begin : g_match
        assign hit[g] = (funct_i == rfn_code(g));
    end

    always_comb begin
        fn_op = '0;
        for (int i = 0; i < NUM_RFN; i++) begin
            if (hit[i]) fn_op = fn_op | rfn_alu(i);
        end
    end

    assign funct_ok_o = |hit;

    always_comb begin
        case (cls_i)
            CLS_ADD:   op_o = AOP_ADD;
            CLS_SUB:   op_o = AOP_SUB;
            CLS_FUNCT: op_o = funct_ok_o ? alu_op_e'(fn_op) : AOP_AND;
            default:   op_o = AOP_AND;
        endcase
    end
endmodule

// File: rtl/ctl_decoder_top.sv
module ctl_decoder_top
    import ctl_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output logic       dst_rd,
    output logic       opb_imm,
    output logic       wb_mem,
    output logic       rf_wr,
    output logic       dm_rd,
    output logic       dm_wr,
    output logic       br_eq,
    output logic       jmp,
    output logic [1:0] alu_cls,
    output logic [3:0] alu_op
);
    ctl_word_t raw_word;
    ctl_word_t fin_word;
    alu_op_e   op_sel;
    logic      funct_ok;

    ctl_main_dec u_main (
        .opcode_i (opcode),
        .word_o   (raw_word)
    );

    ctl_alu_dec u_alu (
        .cls_i      (raw_word.cls),
        .funct_i    (funct),
        .op_o       (op_sel),
        .funct_ok_o (funct_ok)
    );

    // Illegal register-register function: silence everything but the class.
    always_comb begin
        fin_word = raw_word;
        if (raw_word.cls == CLS_FUNCT && !funct_ok) begin
            fin_word     = CTL_QUIET;
            fin_word.cls = CLS_FUNCT;
        end
    end

    assign dst_rd  = fin_word.dst_rd;
    assign opb_imm = fin_word.opb_imm;
    assign wb_mem  = fin_word.wb_mem;
    assign rf_wr   = fin_word.rf_wr;
    assign dm_rd   = fin_word.dm_rd;
    assign dm_wr   = fin_word.dm_wr;
    assign br_eq   = fin_word.br_eq;
    assign jmp     = fin_word.jmp;
    assign alu_cls = fin_word.cls;
    assign alu_op  = op_sel;
endmodule

// File: rtl/ctl_decoder_chk.sv
module ctl_decoder_chk (
    input logic [5:0] opcode,
    input logic [5:0] funct,
    input logic       dst_rd,
    input logic       opb_imm,
    input logic       wb_mem,
    input logic       rf_wr,
    input logic       dm_rd,
    input logic       dm_wr,
    input logic       br_eq,
    input logic       jmp,
    input logic [1:0] alu_cls,
    input logic [3:0] alu_op
);
    logic legal_opc;
    logic legal_fn;

    assign legal_opc = (opcode == 6'b000000) || (opcode == 6'b100011) ||
                       (opcode == 6'b101011) || (opcode == 6'b000100) ||
                       (opcode == 6'b000010);
    assign legal_fn  = (funct == 6'b100000) || (funct == 6'b100010) ||
                       (funct == 6'b100100) || (funct == 6'b100101) ||
                       (funct == 6'b101010);

    always_comb begin
        if (!$isunknown({opcode, funct})) begin
            AST_ONE_ACTION: assert ($countones({rf_wr, dm_wr, br_eq, jmp}) <= 1) else $error("several actions"); // R10
            AST_READ_WRITES_BACK: assert (!dm_rd || (wb_mem && rf_wr)) else $error("load without write-back"); // R10
            AST_BAD_OPC_QUIET: assert (legal_opc || ({dst_rd, opb_imm, wb_mem, rf_wr, dm_rd, dm_wr, br_eq, jmp} == 8'd0 && alu_op == 4'b0000)) else $error("illegal opcode not quiet"); // R8
            AST_BAD_FN_QUIET: assert (opcode != 6'b000000 || legal_fn || (!rf_wr && alu_op == 4'b0000)) else $error("illegal funct not quiet"); // R3
            AST_BRANCH_SUBTRACTS: assert (!br_eq || alu_op == 4'b0110) else $error("branch without subtract"); // R6
            AST_JUMP_NO_STORE: assert (!jmp || (!dm_rd && !dm_wr && !rf_wr)) else $error("jump touches state"); // R7
            AST_MEM_ADDS: assert (!(dm_rd || dm_wr) || (alu_op == 4'b0010 && opb_imm)) else $error("memory access without immediate add"); // R4
        end
    end
endmodule

bind ctl_decoder_top ctl_decoder_chk u_chk (
    .opcode  (opcode),
    .funct   (funct),
    .dst_rd  (dst_rd),
    .opb_imm (opb_imm),
    .wb_mem  (wb_mem),
    .rf_wr   (rf_wr),
    .dm_rd   (dm_rd),
    .dm_wr   (dm_wr),
    .br_eq   (br_eq),
    .jmp     (jmp),
    .alu_cls (alu_cls),
    .alu_op  (alu_op)
);

// File: tb/ctl_decoder_top_tb_top.sv
module ctl_decoder_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'b111111;
    logic [5:0] funct  = 6'b000000;
    logic       dst_rd, opb_imm, wb_mem, rf_wr, dm_rd, dm_wr, br_eq, jmp;
    logic [1:0] alu_cls;
    logic [3:0] alu_op;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ctl_decoder_top dut_i (
        .opcode (opcode), .funct (funct),
        .dst_rd (dst_rd), .opb_imm (opb_imm), .wb_mem (wb_mem),
        .rf_wr (rf_wr), .dm_rd (dm_rd), .dm_wr (dm_wr),
        .br_eq (br_eq), .jmp (jmp), .alu_cls (alu_cls), .alu_op (alu_op)
    );

    // Expected word: {dst_rd,opb_imm,wb_mem,rf_wr,dm_rd,dm_wr,br_eq,jmp,alu_cls[1:0],alu_op[3:0]}
    function automatic logic [13:0] model(input logic [5:0] op, input logic [5:0] fn);
        logic [3:0] fop;
        logic       fok;
        fok = 1'b1;
        case (fn)
            6'b100000: fop = 4'b0010;
            6'b100010: fop = 4'b0110;
            6'b100100: fop = 4'b0000;
            6'b100101: fop = 4'b0001;
            6'b101010: fop = 4'b0111;
            default: begin fop = 4'b0000; fok = 1'b0; end
        endcase
        case (op)
            6'b000000: model = fok ? {8'b1001_0000, 2'b10, fop} : {8'b0, 2'b10, 4'b0000};
            6'b100011: model = {8'b0111_1000, 2'b00, 4'b0010};
            6'b101011: model = {8'b0100_0100, 2'b00, 4'b0010};
            6'b000100: model = {8'b0000_0010, 2'b01, 4'b0110};
            6'b000010: model = {8'b0000_0001, 2'b00, 4'b0010};
            default:   model = {8'b0, 2'b11, 4'b0000};
        endcase
    endfunction

    function automatic string tag(input logic [5:0] op, input logic [5:0] fn);
        case (op)
            6'b000000: tag = (model(op, fn)[10]) ? "R1/R2" : "R3";
            6'b100011: tag = "R4/R9";
            6'b101011: tag = "R5/R9";
            6'b000100: tag = "R6/R9";
            6'b000010: tag = "R7/R9";
            default:   tag = "R8/R9";
        endcase
    endfunction

    function automatic logic [13:0] got();
        return {dst_rd, opb_imm, wb_mem, rf_wr, dm_rd, dm_wr, br_eq, jmp, alu_cls, alu_op};
    endfunction

    task automatic check(input logic [5:0] op, input logic [5:0] fn);
        logic [13:0] exp;
        @(posedge clk);
        #1;
        opcode = op;
        funct  = fn;
        @(negedge clk);
        exp = model(op, fn);
        total++;
        if (got() !== exp) begin
            bad++;
            $display("FAIL %s op=%b fn=%b actual=%b expected=%b", tag(op, fn), op, fn, got(), exp);
        end
        // R10: exclusivity of actions and load write-back pairing
        total++;
        if ($countones({rf_wr, dm_wr, br_eq, jmp}) > 1 || (dm_rd && !(wb_mem && rf_wr))) begin
            bad++;
            $display("FAIL R10 op=%b fn=%b actual=%b expected=exclusive", op, fn, got());
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        logic [5:0] legal_op [5];
        logic [5:0] legal_fn [5];
        legal_op = '{6'b000000, 6'b100011, 6'b101011, 6'b000100, 6'b000010};
        legal_fn = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010};
        void'($urandom(32'd4711));

        repeat (3) @(posedge clk);
        // reset window: illegal opcode presented, outputs must be quiet (R8)
        @(negedge clk);
        total++;
        if (got() !== {8'b0, 2'b11, 4'b0000}) begin
            bad++;
            $display("FAIL R8 reset-state actual=%b expected=%b", got(), {8'b0, 2'b11, 4'b0000});
        end
        @(posedge clk);
        #1 rst = 1'b0;

        // R1, R2: every legal function code
        for (int i = 0; i < 5; i++) check(6'b000000, legal_fn[i]);
        // R3: unlisted function codes
        check(6'b000000, 6'b000000);
        check(6'b000000, 6'b100001);
        check(6'b000000, 6'b111111);
        check(6'b000000, 6'b101011);
        // R4..R7 with legal and illegal funct values (R9)
        for (int i = 1; i < 5; i++) begin
            check(legal_op[i], 6'b000000);
            check(legal_op[i], 6'b100010);
            check(legal_op[i], 6'b101010);
            check(legal_op[i], 6'b111111);
        end
        // R8: neighbours of legal opcodes
        check(6'b000011, 6'b100000);
        check(6'b000101, 6'b100000);
        check(6'b100001, 6'b100010);
        check(6'b101010, 6'b100100);
        check(6'b111111, 6'b101010);
        check(6'b000001, 6'b100101);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [5:0] op;
            logic [5:0] fn;
            op = ($urandom % 4 != 0) ? legal_op[$urandom % 5] : 6'($urandom);
            fn = ($urandom % 3 != 0) ? legal_fn[$urandom % 5] : 6'($urandom);
            check(op, fn);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule